// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration front end of a legacy peripheral hub. The host reaches it through two byte-wide ports that sit next to each other: the index port (port select 0, the base address) and the data port (port select 1, base plus one). A register access is two transfers. The host first writes a register number to the index port, then reads or writes the data port. Nothing in the configuration space can be seen or changed until a key byte has been written twice in a row to the index port. A different key byte closes access again.

Once open, the block answers a global bank: a device-select register, a fixed manufacturer code, a device code and a revision byte. It also holds a per-device bank, one copy for each logical device, with an enable bit and a 16-bit base address. Indices 0xF0 to 0xFF are passed through to downstream device logic. Writes there leave as a one-cycle strobe carrying the data, and reads return the `dev_rd_data` input. Host transfers use a valid/ready request channel and a valid/ready response channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. A waiting response keeps `rsp_valid` and `rsp_data` steady until it is taken.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked. `dev_sel` and `reg_index` are 0, every enable bit and base address is 0, and `rsp_valid` is 0.
- R2: Two accepted index-port writes of 0x87 in a row open the port. `cfg_unlocked` is high from the cycle after the second one.
- R3: An index-port write of any byte other than 0x87, arriving after a first 0x87 and before a second one, discards the first 0x87. A single 0x87 never opens the port.
- R4: While the port is open, an index-port write of 0xAA closes it and leaves `reg_index` unchanged. Any other index-port write is stored as the current index.
- R5: While the port is locked, data-port writes change no register and produce no strobe, and data-port reads return 0xFF.
- R6: Index 0x20 reads the high byte of the device code and 0x21 reads its low byte. Index 0x22 reads the revision byte. Indices 0x23 and 0x24 read 0x19 and 0x34. Writes to these indices are ignored.
- R7: Index 0x07 is the device-select register. It is readable and writable, and its value drives `dev_sel`.
- R8: For the selected device, bit 0 of index 0x30 is its enable and bits 7:1 read 0. Index 0x60 is its base-address high byte and 0x61 is the low byte. Each device keeps its own copy, shown on `dev_enable[d]` and on `dev_base[16*d+15 : 16*d]`.
- R9: Indices that are not implemented read 0 while the port is open. When `dev_sel` is `NUM_DEV` or higher, reads of the per-device indices return 0 and writes to them are ignored.
- R10: A data-port write while the port is open, with the index in 0xF0 to 0xFF, raises `dev_wr_stb` for exactly the next cycle with the written byte on `dev_wr_data`. No other write raises the strobe. Data-port reads of those indices return `dev_rd_data`.
- R11: A read response stays valid with stable data until `rsp_ready` is high. `req_ready` is low exactly while a response is held back.
- R12: An index-port read returns `reg_index` while the port is open and 0xFF while it is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 1 | 0 = index port, 1 = data port |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| cfg_unlocked | output | 1 | Configuration access is open |
| dev_sel | output | 8 | Selected logical device number |
| reg_index | output | 8 | Current register index |
| dev_wr_stb | output | 1 | Write strobe for indices 0xF0-0xFF |
| dev_wr_data | output | 8 | Byte carried with the strobe |
| dev_rd_data | input | 8 | Read byte from the selected device for 0xF0-0xFF |
| dev_enable | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device |

## Verification
Every result appears one clock after the edge that accepts the request. The lock state, the index, the select value, the enables, the base addresses, the strobe and the read response all change at that edge. The bench drives requests on the falling edge and holds each one until the next falling edge that follows an accepting rising edge. It samples every output at that falling edge, so each check reads the value that the single register stage has just produced. For the back-pressure case the bench holds `rsp_ready` low for several falling edges and checks the held response and `req_ready` at each of them.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  localparam logic [BYTE_W-1:0] KEY_OPEN     = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_CLOSE    = 8'hAA;
  localparam logic [BYTE_W-1:0] LOCKED_VALUE = 8'hFF;

  localparam logic [BYTE_W-1:0] IX_SELECT   = 8'h07;
  localparam logic [BYTE_W-1:0] IX_DEVID_HI = 8'h20;
  localparam logic [BYTE_W-1:0] IX_DEVID_LO = 8'h21;
  localparam logic [BYTE_W-1:0] IX_REVISION = 8'h22;
  localparam logic [BYTE_W-1:0] IX_MFR_HI   = 8'h23;
  localparam logic [BYTE_W-1:0] IX_MFR_LO   = 8'h24;
  localparam logic [BYTE_W-1:0] IX_ENABLE   = 8'h30;
  localparam logic [BYTE_W-1:0] IX_BASE_HI  = 8'h60;
  localparam logic [BYTE_W-1:0] IX_BASE_LO  = 8'h61;
  localparam logic [3:0]        PASS_WINDOW = 4'hF;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/sio_cfg_keyfsm.sv
module sio_cfg_keyfsm
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              unlocked,
  output logic              load_index
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KS_LOCKED: state_d = (wdata == KEY_OPEN) ? KS_ARMED : KS_LOCKED;
        KS_ARMED:  state_d = (wdata == KEY_OPEN) ? KS_OPEN  : KS_LOCKED;
        KS_OPEN:   state_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked   = (state_q == KS_OPEN);
  assign load_index = idx_wr && (state_q == KS_OPEN) && (wdata != KEY_CLOSE);
endmodule

// File: rtl/sio_cfg_ldbank.sv
module sio_cfg_ldbank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          sel,
  input  logic [BYTE_W-1:0]          index,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [NUM_DEV-1:0]         en_o,
  output logic [NUM_DEV*ADDR_W-1:0]  base_o,
  output logic [BYTE_W-1:0]          rd_o
);
  localparam int HI_OFS = ADDR_W - BYTE_W;

  logic [NUM_DEV-1:0]        en_q;
  logic [NUM_DEV*ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      base_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_DEV; i++) begin
        if (sel == BYTE_W'(i)) begin
          unique case (index)
            IX_ENABLE:  en_q[i] <= wdata[0];
            IX_BASE_HI: base_q[i*ADDR_W+HI_OFS +: BYTE_W] <= wdata;
            IX_BASE_LO: base_q[i*ADDR_W +: BYTE_W] <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (sel == BYTE_W'(i)) begin
        unique case (index)
          IX_ENABLE:  rd_o = {{(BYTE_W-1){1'b0}}, en_q[i]};
          IX_BASE_HI: rd_o = base_q[i*ADDR_W+HI_OFS +: BYTE_W];
          IX_BASE_LO: rd_o = base_q[i*ADDR_W +: BYTE_W];
          default:    rd_o = '0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_out
    assign en_o[g]                    = en_q[g];
    assign base_o[g*ADDR_W +: ADDR_W] = base_q[g*ADDR_W +: ADDR_W];
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_DEV = 4,
  parameter logic [15:0] DEV_ID  = 16'h0A31,
  parameter logic [7:0]  REV_ID  = 8'h12,
  parameter logic [15:0] MFR_ID  = 16'h1934
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic                      req_port,
  input  logic [7:0]                req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [7:0]                rsp_data,
  output logic                      cfg_unlocked,
  output logic [7:0]                dev_sel,
  output logic [7:0]                reg_index,
  output logic                      dev_wr_stb,
  output logic [7:0]                dev_wr_data,
  input  logic [7:0]                dev_rd_data,
  output logic [NUM_DEV-1:0]        dev_enable,
  output logic [NUM_DEV*16-1:0]     dev_base
);
  logic              accept, idx_wr, data_wr, open_q, load_index;
  logic [BYTE_W-1:0] index_q, sel_q, bank_rd, data_rd, rd_val;
  logic              rsp_valid_q, stb_q;
  logic [BYTE_W-1:0] rsp_data_q, stb_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign idx_wr    = accept && req_write && !req_port;
  assign data_wr   = accept && req_write && req_port && open_q;

  sio_cfg_keyfsm u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (idx_wr),
    .wdata      (req_wdata),
    .unlocked   (open_q),
    .load_index (load_index)
  );

  sio_cfg_ldbank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (data_wr),
    .sel    (sel_q),
    .index  (index_q),
    .wdata  (req_wdata),
    .en_o   (dev_enable),
    .base_o (dev_base),
    .rd_o   (bank_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      sel_q   <= '0;
    end else begin
      if (load_index) index_q <= req_wdata;
      if (data_wr && index_q == IX_SELECT) sel_q <= req_wdata;
    end
  end

  always_comb begin
    if (index_q[7:4] == PASS_WINDOW) begin
      data_rd = dev_rd_data;
    end else begin
      unique case (index_q)
        IX_SELECT:   data_rd = sel_q;
        IX_DEVID_HI: data_rd = DEV_ID[15:8];
        IX_DEVID_LO: data_rd = DEV_ID[7:0];
        IX_REVISION: data_rd = REV_ID;
        IX_MFR_HI:   data_rd = MFR_ID[15:8];
        IX_MFR_LO:   data_rd = MFR_ID[7:0];
        default:     data_rd = bank_rd;
      endcase
    end
  end

  always_comb begin
    if (!open_q)       rd_val = LOCKED_VALUE;
    else if (req_port) rd_val = data_rd;
    else               rd_val = index_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      stb_q       <= 1'b0;
      stb_data_q  <= '0;
    end else begin
      if (accept && !req_write) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_val;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
      stb_q <= data_wr && (index_q[7:4] == PASS_WINDOW);
      if (data_wr && (index_q[7:4] == PASS_WINDOW)) stb_data_q <= req_wdata;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign cfg_unlocked = open_q;
  assign dev_sel      = sel_q;
  assign reg_index    = index_q;
  assign dev_wr_stb   = stb_q;
  assign dev_wr_data  = stb_data_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       req_port,
  input logic [7:0] req_wdata,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       cfg_unlocked,
  input logic [7:0] dev_sel,
  input logic [7:0] reg_index,
  input logic       dev_wr_stb
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R11
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R2
  open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(acc && req_write && !req_port && req_wdata == 8'h87));

  // R4
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_unlocked) |-> $past(acc && req_write && !req_port && req_wdata == 8'hAA));

  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && req_port && !cfg_unlocked |=> rsp_valid && rsp_data == 8'hFF);

  // R7
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_sel) |-> $past(acc && req_write && req_port && cfg_unlocked && reg_index == 8'h07));

  // R10
  stb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_stb |-> reg_index[7:4] == 4'hF && $past(acc && req_write && req_port && cfg_unlocked));
endmodule

bind sio_cfg_port sio_cfg_port_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_port     (req_port),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_data     (rsp_data),
  .cfg_unlocked (cfg_unlocked),
  .dev_sel      (dev_sel),
  .reg_index    (reg_index),
  .dev_wr_stb   (dev_wr_stb)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;
  localparam int          ND   = 4;
  localparam logic [15:0] DID  = 16'h0A31;
  localparam logic [7:0]  REV  = 8'h12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_port = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, cfg_unlocked, dev_wr_stb;
  logic [7:0] rsp_data, dev_sel, reg_index, dev_wr_data, dev_rd_data;
  logic [ND-1:0] dev_enable;
  logic [ND*16-1:0] dev_base;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign dev_rd_data = reg_index ^ 8'h5A;

  sio_cfg_port #(.NUM_DEV(ND), .DEV_ID(DID), .REV_ID(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cfg_unlocked(cfg_unlocked), .dev_sel(dev_sel), .reg_index(reg_index),
    .dev_wr_stb(dev_wr_stb), .dev_wr_data(dev_wr_data), .dev_rd_data(dev_rd_data),
    .dev_enable(dev_enable), .dev_base(dev_base)
  );

  // reference model
  bit m_open = 0, m_armed = 0;
  logic [7:0] m_idx = 0, m_sel = 0;
  logic [ND-1:0] m_en = '0;
  logic [15:0] m_base [ND];

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(bit port);
    if (!m_open) return 8'hFF;
    if (!port) return m_idx;
    if (m_idx[7:4] == 4'hF) return m_idx ^ 8'h5A;
    case (m_idx)
      8'h07: return m_sel;
      8'h20: return DID[15:8];
      8'h21: return DID[7:0];
      8'h22: return REV;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      8'h30: return (m_sel < ND) ? {7'b0, m_en[m_sel[1:0]]} : 8'h00;
      8'h60: return (m_sel < ND) ? m_base[m_sel[1:0]][15:8] : 8'h00;
      8'h61: return (m_sel < ND) ? m_base[m_sel[1:0]][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic send(bit w, bit p, logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_port = p; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(bit p, logic [7:0] d);
    bit stb_exp;
    stb_exp = 0;
    if (!p) begin
      if (!m_open) begin
        if (m_armed && d == 8'h87) begin m_open = 1; m_armed = 0; end
        else m_armed = (d == 8'h87);
      end else if (d == 8'hAA) m_open = 0;
      else m_idx = d;
    end else if (m_open) begin
      if (m_idx[7:4] == 4'hF) stb_exp = 1;
      else if (m_idx == 8'h07) m_sel = d;
      else if (m_sel < ND) begin
        if (m_idx == 8'h30) m_en[m_sel[1:0]] = d[0];
        if (m_idx == 8'h60) m_base[m_sel[1:0]][15:8] = d;
        if (m_idx == 8'h61) m_base[m_sel[1:0]][7:0] = d;
      end
    end
    send(1'b1, p, d);
    chk("R10 strobe", {15'b0, dev_wr_stb}, {15'b0, stb_exp});
    if (stb_exp) chk("R10 strobe data", {8'b0, dev_wr_data}, {8'b0, d});
    chk("R2 R3 R4 lock state", {15'b0, cfg_unlocked}, {15'b0, m_open});
  endtask

  task automatic rd(string tag, bit p);
    logic [7:0] e;
    e = exp_read(p);
    send(1'b0, p, 8'h00);
    chk({tag, " valid"}, {15'b0, rsp_valid}, 16'd1);
    chk(tag, {8'b0, rsp_data}, {8'b0, e});
  endtask

  task automatic reg_access(logic [7:0] ix, logic [7:0] d);
    wr(1'b0, ix);
    wr(1'b1, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    for (int i = 0; i < ND; i++) m_base[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 unlocked", {15'b0, cfg_unlocked}, 16'd0);
    chk("R1 dev_sel", {8'b0, dev_sel}, 16'd0);
    chk("R1 reg_index", {8'b0, reg_index}, 16'd0);
    chk("R1 enables", {12'b0, dev_enable}, 16'd0);
    chk("R1 bases", dev_base[15:0] | dev_base[31:16] | dev_base[47:32] | dev_base[63:48], 16'd0);
    chk("R1 rsp_valid", {15'b0, rsp_valid}, 16'd0);

    // R5 / R12 locked reads
    rd("R5 locked data read", 1'b1);
    rd("R12 locked index read", 1'b0);

    // R3 interrupted key, then single key
    wr(1'b0, 8'h87); wr(1'b0, 8'h20); wr(1'b0, 8'h87);
    chk("R3 still locked", {15'b0, cfg_unlocked}, 16'd0);
    // R2 open
    wr(1'b0, 8'h87);
    chk("R2 opened", {15'b0, cfg_unlocked}, 16'd1);

    // R6 identification
    wr(1'b0, 8'h20); rd("R6 devid hi", 1'b1);
    wr(1'b0, 8'h21); rd("R6 devid lo", 1'b1);
    wr(1'b0, 8'h22); rd("R6 revision", 1'b1);
    wr(1'b0, 8'h23); rd("R6 mfr hi", 1'b1);
    wr(1'b1, 8'h55); rd("R6 mfr hi after write", 1'b1);
    wr(1'b0, 8'h24); rd("R6 mfr lo", 1'b1);
    rd("R12 open index read", 1'b0);

    // R7 / R8 device 2
    reg_access(8'h07, 8'h02);
    chk("R7 dev_sel port", {8'b0, dev_sel}, 16'h0002);
    rd("R7 select read", 1'b1);
    reg_access(8'h30, 8'hFF); rd("R8 enable bit0 only", 1'b1);
    reg_access(8'h60, 8'h12); reg_access(8'h61, 8'h34);
    chk("R8 base port", dev_base[47:32], 16'h1234);
    chk("R8 enable port", {12'b0, dev_enable}, 16'h0004);
    reg_access(8'h07, 8'h01); wr(1'b0, 8'h60);
    rd("R8 other device separate", 1'b1);

    // R9 out of range and unimplemented
    reg_access(8'h07, 8'h09); reg_access(8'h30, 8'h01);
    rd("R9 out of range read", 1'b1);
    chk("R9 enables unchanged", {12'b0, dev_enable}, 16'h0004);
    wr(1'b0, 8'h45); rd("R9 unimplemented read", 1'b1);

    // R10 pass-through window
    reg_access(8'hF5, 8'hC3);
    rd("R10 window read", 1'b1);
    reg_access(8'hEF, 8'h11);

    // R11 back-pressure
    wr(1'b0, 8'h07);
    rsp_ready = 1'b0;
    send(1'b0, 1'b1, 8'h00);
    held = rsp_data;
    chk("R11 value", {8'b0, held}, 16'h0009);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 held valid", {15'b0, rsp_valid}, 16'd1);
      chk("R11 held data", {8'b0, rsp_data}, {8'b0, held});
      chk("R11 req_ready low", {15'b0, req_ready}, 16'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", {15'b0, rsp_valid}, 16'd0);

    // R4 close, R5 ignored write
    wr(1'b0, 8'hAA);
    chk("R4 index kept", {8'b0, reg_index}, 16'h0007);
    wr(1'b1, 8'h03);
    chk("R5 sel unchanged", {8'b0, dev_sel}, 16'h0009);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd("R5 select after locked write", 1'b1);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      logic [7:0] ix;
      r = $urandom % 10;
      case ($urandom % 12)
        0, 1, 2: ix = 8'h87;
        3: ix = 8'hAA;
        4: ix = 8'h07;
        5: ix = 8'h20 + 8'($urandom % 5);
        6: ix = 8'h30;
        7: ix = 8'h60;
        8: ix = 8'h61;
        9: ix = 8'hF0 | 8'($urandom % 16);
        default: ix = 8'($urandom);
      endcase
      if (r < 4) wr(1'b0, ix);
      else if (r < 7) wr(1'b1, (ix == 8'h07) ? 8'($urandom % 6) : 8'($urandom));
      else if (r < 9) rd("R6 R8 R9 random data read", 1'b1);
      else rd("R12 random index read", 1'b0);
    end
    chk("R8 final enables", {12'b0, dev_enable}, {12'b0, m_en});
    for (int i = 0; i < ND; i++) chk("R8 final base", dev_base[i*16 +: 16], m_base[i]);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule